// File: doc/BRIEF.md
# Extended-to-double store converter

The block turns one value from a floating-point register file into a 64-bit IEEE double-precision word ready to be written to memory. The source value arrives as a sign, a 64-bit significand with an explicit integer bit, a signed unbiased exponent and a class tag. The block narrows the significand to 53 bits under one of four rounding modes. It handles results too small for the normal range by shifting them into the subnormal position. It passes zero, infinity and NaN classes through and replaces the result with fixed patterns when an exception is masked. It also decides whether the word may be written at all.

Each accepted input produces, one clock later, the result word, a write-enable and six exception flags: invalid, stack underflow, overflow, underflow, precision and rounded-up. Because the datapath is purely combinational between the input and the output registers, one value is accepted on every clock. The register stack and the memory write are handled outside the block.

Top module: `ext_to_double_store`

## Requirements
- R1: With rndMode 0 (nearest), a normal-range value (exponent at least -1022) is incremented at significand bit 11 when the 11 dropped bits exceed 0x400, or equal 0x400 while bit 11 is 1. Otherwise it is truncated. The result is {sign, exponent+1023, significand bits 62..11}.
- R2: rndMode 1 (toward minus) increments only negative values whose dropped part is nonzero. rndMode 2 (toward plus) increments only such positive values. rndMode 3 (chop) never increments.
- R3: When the increment carries out of the 53-bit kept significand, the fraction becomes zero and the exponent grows by one. The overflow test is made on the grown exponent.
- R4: An exponent above 1023 after rounding raises overflow. If overflow is masked, precision and rounded-up are also raised. The write happens only when both overflow and precision are masked, and the word is then a signed infinity (exponent field all ones, fraction zero).
- R5: A valid value with exponent below -1022 is shifted right by (-1011 - exponent) bit positions, capped at 65, and rounded as an integer under the current mode. The word is {sign, integer bits 62..0}, so rounding up to 2^52 yields the smallest normal number. If any bits are lost, underflow and precision are raised, and the write happens only when underflow and precision are both masked. An exact result writes with no flags.
- R6: A NaN (tag 3) yields exponent field all ones and fraction = significand bits 62..11. If bit 62 (quiet bit) is clear, invalid is raised, fraction bit 51 is forced to 1, and the write happens only when invalid is masked. A NaN with the quiet bit set writes with no flags.
- R7: An empty source (tag 4, and the unused codes 5 to 7) raises stack underflow only. If invalid is masked it writes 0xFFF8_0000_0000_0000, ignoring the sign; otherwise it writes nothing.
- R8: Tag 1 (zero) writes a signed zero, and tag 2 (infinity) writes a signed infinity, both with no flags. Tag 0 marks a finite valid value.
- R9: The sign input appears in bit 63 of every result except the empty-source pattern.
- R10: Precision is raised whenever rounding drops nonzero bits. Rounded-up is raised exactly when the magnitude was incremented, and never without precision.
- R11: The outputs follow an accepted input (inValid high) by exactly one cycle, with outValid high. In a cycle after no input, outValid, outWrite and all flags are low.
- R12: After reset, outValid, outWrite, outData and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input value present this cycle |
| inSign | input | 1 | Sign of source (1 = negative) |
| inSig | input | 64 | Significand, bit 63 is the integer bit |
| inExp | input | 16 | Unbiased exponent, two's complement |
| inTag | input | 3 | Class: 0 valid, 1 zero, 2 infinity, 3 NaN, 4 empty |
| rndMode | input | 2 | 0 nearest, 1 toward minus, 2 toward plus, 3 chop |
| maskInvalid | input | 1 | Invalid exception masked |
| maskOverflow | input | 1 | Overflow exception masked |
| maskUnderflow | input | 1 | Underflow exception masked |
| maskPrecision | input | 1 | Precision exception masked |
| outValid | output | 1 | Result present |
| outWrite | output | 1 | Result may be written to memory |
| outData | output | 64 | Double-precision result |
| flgInvalid | output | 1 | Invalid operation |
| flgStackUnder | output | 1 | Empty source register |
| flgOverflow | output | 1 | Exponent too large |
| flgUnderflow | output | 1 | Inexact subnormal result |
| flgPrecision | output | 1 | Bits were lost |
| flgRoundUp | output | 1 | Magnitude was incremented |

## Verification
Rounding is exercised with dropped fields just below, exactly at and just above the half point, with both values of the kept lowest bit. This separates true ties from ordinary round-to-nearest. The directed modes get each sign, so an increment applied to the wrong sign shows up. An all-ones significand is used at a small exponent and again at exponent 1023, which separates carry renormalisation from overflow. The mask combinations show which exception gates the write. The subnormal path is driven at the boundary exponent -1023, deep below it, and past the shift cap, and it is also driven with a value that rounds up into the smallest normal. Signalling NaNs, quiet NaNs and empty sources are each tried with invalid masked and unmasked. A long pseudo-random stream then mixes all classes, modes and masks, with idle cycles in between.

// File: rtl/ext2dbl_pkg.sv
package ext2dbl_pkg;

  typedef enum logic [2:0] {
    TAG_VALID = 3'd0,
    TAG_ZERO  = 3'd1,
    TAG_INF   = 3'd2,
    TAG_NAN   = 3'd3,
    TAG_EMPTY = 3'd4
  } srcTag_e;

  // which candidate word the datapath registers
  typedef enum logic [2:0] {
    PICK_NORM,
    PICK_DEN,
    PICK_INF,
    PICK_NAN,
    PICK_ZERO,
    PICK_EMPTY
  } pick_e;

  // control -> datapath strobes
  typedef struct packed {
    logic  load;
    pick_e pick;
    logic  forceQuiet;
  } strobe_t;

  // datapath -> control observations
  typedef struct packed {
    logic isDen;
    logic ovf;
    logic lossN;
    logic incN;
    logic lossD;
    logic incD;
    logic quietClear;
  } dpStat_t;

  typedef struct packed {
    logic inv;
    logic stkUnd;
    logic ovf;
    logic unf;
    logic prec;
    logic up;
  } flags_t;

  // increment decision shared by both rounding paths
  function automatic logic roundBump(input logic [1:0] mode, input logic neg,
                                     input logic lsb, input logic half,
                                     input logic sticky);
    case (mode)
      2'd0:    return half & (sticky | lsb);
      2'd1:    return neg & (half | sticky);
      2'd2:    return ~neg & (half | sticky);
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ext2dbl_rounder.sv
module ext2dbl_rounder
  import ext2dbl_pkg::*;
#(
  parameter int KEEP_W = 53
) (
  input  logic [1:0]        mode,
  input  logic              neg,
  input  logic [KEEP_W-1:0] kept,
  input  logic              half,
  input  logic              sticky,
  output logic [KEEP_W:0]   sum,
  output logic              lost,
  output logic              bump
);

  always_comb begin
    lost = half | sticky;
    bump = roundBump(mode, neg, kept[0], half, sticky);
    sum  = {1'b0, kept} + {{KEEP_W{1'b0}}, bump};
  end

endmodule

// File: rtl/ext2dbl_datapath.sv
module ext2dbl_datapath
  import ext2dbl_pkg::*;
#(
  parameter int SIG_W  = 64,
  parameter int EXP_W  = 16,
  parameter int EXPF_W = 11,
  parameter int FRAC_W = 52
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inSign,
  input  logic [SIG_W-1:0]          inSig,
  input  logic [EXP_W-1:0]          inExp,
  input  logic [1:0]                rndMode,
  input  strobe_t                   strobe,
  output dpStat_t                   stat,
  output logic [EXPF_W+FRAC_W:0]    outData
);

  localparam int DROP   = SIG_W - 1 - FRAC_W;
  localparam int BIAS   = (1 << (EXPF_W - 1)) - 1;
  localparam int EMIN   = 1 - BIAS;
  localparam int OUT_W  = 1 + EXPF_W + FRAC_W;
  localparam int MAX_SH = SIG_W + 1;
  localparam int SH_W   = $clog2(MAX_SH + 1);
  localparam int WIDE_W = 2 * SIG_W;

  logic signed [EXP_W+1:0] sxExp;
  assign sxExp = $signed({{2{inExp[EXP_W-1]}}, inExp});

  // ---------------- normal-range rounding ----------------
  logic [FRAC_W:0]   keepN;
  logic [DROP-1:0]   remN;
  logic [FRAC_W+1:0] sumN;
  logic              lossN, bumpN, carryN;
  logic [FRAC_W-1:0] fracN;
  logic signed [EXP_W+1:0] expAdj;
  logic [EXPF_W-1:0] biasN;

  assign keepN = inSig[SIG_W-1:DROP];
  assign remN  = inSig[DROP-1:0];

  ext2dbl_rounder #(.KEEP_W(FRAC_W + 1)) u_rndNorm (
    .mode   (rndMode),
    .neg    (inSign),
    .kept   (keepN),
    .half   (remN[DROP-1]),
    .sticky (|remN[DROP-2:0]),
    .sum    (sumN),
    .lost   (lossN),
    .bump   (bumpN)
  );

  always_comb begin
    carryN = sumN[FRAC_W+1];
    // carry out: shift right by one, exponent grows
    fracN  = carryN ? sumN[FRAC_W:1] : sumN[FRAC_W-1:0];
    expAdj = sxExp + $signed({{(EXP_W+1){1'b0}}, carryN});
    biasN  = EXPF_W'(expAdj + BIAS);
  end

  // ---------------- subnormal path ----------------
  logic signed [EXP_W+1:0] shRaw;
  logic [SH_W-1:0]   shAmt;
  logic [WIDE_W-1:0] wide;
  logic [SIG_W-1:0]  intD, fracD;
  logic [SIG_W:0]    sumD;
  logic              lossD, bumpD;

  always_comb begin
    shRaw = $signed((EXP_W + 2)'(EMIN + DROP)) - sxExp;
    shAmt = (shRaw > $signed((EXP_W + 2)'(MAX_SH))) ? SH_W'(MAX_SH) : shRaw[SH_W-1:0];
    wide  = {inSig, {SIG_W{1'b0}}} >> shAmt;
    intD  = wide[WIDE_W-1:SIG_W];
    fracD = wide[SIG_W-1:0];
  end

  ext2dbl_rounder #(.KEEP_W(SIG_W)) u_rndDen (
    .mode   (rndMode),
    .neg    (inSign),
    .kept   (intD),
    .half   (fracD[SIG_W-1]),
    .sticky (|fracD[SIG_W-2:0]),
    .sum    (sumD),
    .lost   (lossD),
    .bump   (bumpD)
  );

  // ---------------- observations for control ----------------
  always_comb begin
    stat.isDen      = sxExp < $signed((EXP_W + 2)'(EMIN));
    stat.ovf        = expAdj > $signed((EXP_W + 2)'(BIAS));
    stat.lossN      = lossN;
    stat.incN       = bumpN;
    stat.lossD      = lossD;
    stat.incD       = bumpD;
    stat.quietClear = ~inSig[SIG_W-2];
  end

  // ---------------- result selection and register ----------------
  logic [FRAC_W-1:0] nanFrac;
  logic [OUT_W-1:0]  nextData;
  logic [OUT_W-1:0]  dataQ;

  always_comb begin
    nanFrac = inSig[SIG_W-2 -: FRAC_W] | {strobe.forceQuiet, {(FRAC_W-1){1'b0}}};
    case (strobe.pick)
      PICK_NORM: nextData = {inSign, biasN, fracN};
      PICK_DEN:  nextData = {inSign, sumD[OUT_W-2:0]};
      PICK_INF:  nextData = {inSign, {EXPF_W{1'b1}}, {FRAC_W{1'b0}}};
      PICK_NAN:  nextData = {inSign, {EXPF_W{1'b1}}, nanFrac};
      PICK_ZERO: nextData = {inSign, {(OUT_W-1){1'b0}}};
      default:   nextData = {1'b1, {EXPF_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            dataQ <= '0;
    else if (strobe.load) dataQ <= nextData;
  end

  assign outData = dataQ;

  // R5
  den_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.pick == PICK_DEN) |-> (sumD[SIG_W:FRAC_W+1] == '0));

  // R3
  carry_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.pick == PICK_NORM && sumN[FRAC_W+1])
      |=> (dataQ[FRAC_W-1:0] == '0));

endmodule

// File: rtl/ext2dbl_control.sv
module ext2dbl_control
  import ext2dbl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [2:0] inTag,
  input  logic       maskInvalid,
  input  logic       maskOverflow,
  input  logic       maskUnderflow,
  input  logic       maskPrecision,
  input  dpStat_t    stat,
  output strobe_t    strobe,
  output logic       outValid,
  output logic       outWrite,
  output flags_t     flags
);

  flags_t flg;
  logic   wr;

  always_comb begin
    flg               = '0;
    wr                = 1'b0;
    strobe.load       = inValid;
    strobe.pick       = PICK_EMPTY;
    strobe.forceQuiet = 1'b0;
    case (inTag)
      TAG_ZERO: begin
        strobe.pick = PICK_ZERO;
        wr          = 1'b1;
      end
      TAG_INF: begin
        strobe.pick = PICK_INF;
        wr          = 1'b1;
      end
      TAG_NAN: begin
        strobe.pick = PICK_NAN;
        if (stat.quietClear) begin
          flg.inv           = 1'b1;
          strobe.forceQuiet = 1'b1;
          wr                = maskInvalid;
        end else begin
          wr = 1'b1;
        end
      end
      TAG_VALID: begin
        if (stat.isDen) begin
          strobe.pick = PICK_DEN;
          flg.unf     = stat.lossD;
          flg.prec    = stat.lossD;
          flg.up      = stat.incD;
          wr          = !stat.lossD || (maskUnderflow && maskPrecision);
        end else if (stat.ovf) begin
          strobe.pick = PICK_INF;
          flg.ovf     = 1'b1;
          flg.prec    = stat.lossN || maskOverflow;
          flg.up      = stat.incN || maskOverflow;
          wr          = maskOverflow && maskPrecision;
        end else begin
          strobe.pick = PICK_NORM;
          flg.prec    = stat.lossN;
          flg.up      = stat.incN;
          wr          = 1'b1;
        end
      end
      default: begin
        flg.stkUnd = 1'b1;
        wr         = maskInvalid;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outWrite <= 1'b0;
      flags    <= '0;
    end else begin
      outValid <= inValid;
      outWrite <= inValid & wr;
      flags    <= inValid ? flg : '0;
    end
  end

  // R10
  up_prec_chk: assert property (@(posedge clk) disable iff (!rstN)
    flags.up |-> flags.prec);

  // R5
  unf_prec_chk: assert property (@(posedge clk) disable iff (!rstN)
    flags.unf |-> flags.prec);

  // R7
  stack_alone_chk: assert property (@(posedge clk) disable iff (!rstN)
    flags.stkUnd |-> !(flags.ovf || flags.unf || flags.prec || flags.up || flags.inv));

endmodule

// File: rtl/ext_to_double_store.sv
module ext_to_double_store
  import ext2dbl_pkg::*;
#(
  parameter int SIG_W  = 64,
  parameter int EXP_W  = 16,
  parameter int EXPF_W = 11,
  parameter int FRAC_W = 52
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic                   inSign,
  input  logic [SIG_W-1:0]       inSig,
  input  logic [EXP_W-1:0]       inExp,
  input  logic [2:0]             inTag,
  input  logic [1:0]             rndMode,
  input  logic                   maskInvalid,
  input  logic                   maskOverflow,
  input  logic                   maskUnderflow,
  input  logic                   maskPrecision,
  output logic                   outValid,
  output logic                   outWrite,
  output logic [EXPF_W+FRAC_W:0] outData,
  output logic                   flgInvalid,
  output logic                   flgStackUnder,
  output logic                   flgOverflow,
  output logic                   flgUnderflow,
  output logic                   flgPrecision,
  output logic                   flgRoundUp
);

  localparam int OUT_W = 1 + EXPF_W + FRAC_W;
  localparam logic [OUT_W-1:0] EMPTY_PAT = {1'b1, {EXPF_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  strobe_t strobe;
  dpStat_t stat;
  flags_t  flagsQ;

  ext2dbl_control u_ctl (
    .clk           (clk),
    .rstN          (rstN),
    .inValid       (inValid),
    .inTag         (inTag),
    .maskInvalid   (maskInvalid),
    .maskOverflow  (maskOverflow),
    .maskUnderflow (maskUnderflow),
    .maskPrecision (maskPrecision),
    .stat          (stat),
    .strobe        (strobe),
    .outValid      (outValid),
    .outWrite      (outWrite),
    .flags         (flagsQ)
  );

  ext2dbl_datapath #(
    .SIG_W (SIG_W),
    .EXP_W (EXP_W),
    .EXPF_W(EXPF_W),
    .FRAC_W(FRAC_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .inSign  (inSign),
    .inSig   (inSig),
    .inExp   (inExp),
    .rndMode (rndMode),
    .strobe  (strobe),
    .stat    (stat),
    .outData (outData)
  );

  assign flgInvalid    = flagsQ.inv;
  assign flgStackUnder = flagsQ.stkUnd;
  assign flgOverflow   = flagsQ.ovf;
  assign flgUnderflow  = flagsQ.unf;
  assign flgPrecision  = flagsQ.prec;
  assign flgRoundUp    = flagsQ.up;

  // R4
  ovf_inf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outWrite && flgOverflow) |-> (outData[OUT_W-2:0] == {{EXPF_W{1'b1}}, {FRAC_W{1'b0}}}));

  // R7
  empty_pattern_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outWrite && flgStackUnder) |-> (outData == EMPTY_PAT));

  // R6
  nan_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outWrite && flgInvalid) |-> (outData[FRAC_W-1] && (&outData[OUT_W-2:FRAC_W])));

  // R11
  write_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outWrite |-> outValid);

  // R11
  idle_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !(flgInvalid || flgStackUnder || flgOverflow || flgUnderflow || flgPrecision || flgRoundUp));

endmodule

// File: tb/test_ext_to_double_store.sv
module test_ext_to_double_store;

  typedef struct packed {
    logic        v;
    logic        w;
    logic [63:0] d;
    logic [5:0]  f;   // inv, stkUnd, ovf, unf, prec, up
  } expect_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inSign = 1'b0;
  logic [63:0] inSig = '0;
  logic [15:0] inExp = '0;
  logic [2:0]  inTag = '0;
  logic [1:0]  rndMode = '0;
  logic maskInvalid = 1'b1, maskOverflow = 1'b1, maskUnderflow = 1'b1, maskPrecision = 1'b1;
  logic outValid, outWrite;
  logic [63:0] outData;
  logic flgInvalid, flgStackUnder, flgOverflow, flgUnderflow, flgPrecision, flgRoundUp;

  int checks = 0;
  int fails  = 0;
  expect_t expQ[$];
  string   reqQ[$];
  logic [63:0] rngState = 64'h9E37_79B9_7F4A_7C15;

  always #4 clk = ~clk;

  ext_to_double_store i_ext_to_double_store (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSign(inSign), .inSig(inSig),
    .inExp(inExp), .inTag(inTag), .rndMode(rndMode), .maskInvalid(maskInvalid),
    .maskOverflow(maskOverflow), .maskUnderflow(maskUnderflow), .maskPrecision(maskPrecision),
    .outValid(outValid), .outWrite(outWrite), .outData(outData),
    .flgInvalid(flgInvalid), .flgStackUnder(flgStackUnder), .flgOverflow(flgOverflow),
    .flgUnderflow(flgUnderflow), .flgPrecision(flgPrecision), .flgRoundUp(flgRoundUp)
  );

  function automatic logic [63:0] nextRand();
    rngState ^= rngState << 13;
    rngState ^= rngState >> 7;
    rngState ^= rngState << 17;
    return rngState;
  endfunction

  // behavioural model built from the requirements
  function automatic expect_t refModel(logic sgn, logic [63:0] sig, int ex, int tag, int mode,
                                       logic mi, logic mo, logic mu, logic mp);
    expect_t r;
    logic [51:0] frac;
    logic [63:0] kept, ip;
    int unsigned rem;
    int e, s;
    logic bump, half, sticky, lost;
    r = '0;
    r.v = 1'b1;
    case (tag)
      1: begin r.w = 1'b1; r.d = {sgn, 63'd0}; end                         // R8
      2: begin r.w = 1'b1; r.d = {sgn, 11'h7ff, 52'd0}; end                // R8
      3: begin                                                             // R6
        frac = sig[62:11];
        if (!sig[62]) begin r.f[5] = 1'b1; frac[51] = 1'b1; r.w = mi; end
        else r.w = 1'b1;
        r.d = {sgn, 11'h7ff, frac};
      end
      0: begin
        if (ex >= -1022) begin                                             // R1 R2 R3 R4
          kept = sig >> 11;
          rem  = int'(sig % 64'd2048);
          case (mode)
            0: bump = (rem > 1024) || (rem == 1024 && kept[0]);
            1: bump = sgn && rem != 0;
            2: bump = !sgn && rem != 0;
            default: bump = 1'b0;
          endcase
          kept = kept + 64'(bump);
          e = ex;
          if (kept == (64'd1 << 53)) begin kept = 64'd1 << 52; e = e + 1; end
          r.f[1] = rem != 0;
          r.f[0] = bump;
          if (e > 1023) begin
            r.f[3] = 1'b1;
            if (mo) begin r.f[1] = 1'b1; r.f[0] = 1'b1; end
            r.w = mo && mp;
            r.d = {sgn, 11'h7ff, 52'd0};
          end else begin
            r.w = 1'b1;
            r.d = {sgn, 11'(e + 1023), kept[51:0]};
          end
        end else begin                                                     // R5
          s = -1011 - ex;
          if (s > 65) s = 65;
          half = 1'b0;
          sticky = 1'b0;
          for (int b = 0; b < 64; b++) begin
            if (b == s - 1) half = sig[b];
            else if (b < s - 1) sticky = sticky | sig[b];
          end
          ip = (s >= 64) ? 64'd0 : (sig >> s);
          lost = half | sticky;
          case (mode)
            0: bump = half && (sticky || ip[0]);
            1: bump = sgn && lost;
            2: bump = !sgn && lost;
            default: bump = 1'b0;
          endcase
          ip = ip + 64'(bump);
          r.f[2] = lost;
          r.f[1] = lost;
          r.f[0] = bump;
          r.w = !lost || (mu && mp);
          r.d = {sgn, ip[62:0]};
        end
      end
      default: begin                                                       // R7
        r.f[4] = 1'b1;
        r.w = mi;
        r.d = 64'hFFF8_0000_0000_0000;
      end
    endcase
    return r;
  endfunction

  task automatic checkOut();
    expect_t e;
    string rq;
    logic [5:0] got;
    logic bad;
    if (expQ.size() == 0) return;
    e  = expQ.pop_front();
    rq = reqQ.pop_front();
    got = {flgInvalid, flgStackUnder, flgOverflow, flgUnderflow, flgPrecision, flgRoundUp};
    bad = (outValid !== e.v) || (outWrite !== e.w) || (got !== e.f) || (e.w && outData !== e.d);
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL %s: got valid=%0b write=%0b flags=%06b data=%h, expected valid=%0b write=%0b flags=%06b data=%h",
               rq, outValid, outWrite, got, outData, e.v, e.w, e.f, e.d);
    end
  endtask

  task automatic drive(input logic sgn, input logic [63:0] sig, input int ex, input int tag,
                       input int mode, input logic [3:0] msk, input string req);
    @(negedge clk);
    checkOut();
    inValid = 1'b1; inSign = sgn; inSig = sig; inExp = 16'(ex); inTag = 3'(tag);
    rndMode = 2'(mode);
    {maskInvalid, maskOverflow, maskUnderflow, maskPrecision} = msk;
    expQ.push_back(refModel(sgn, sig, ex, tag, mode, msk[3], msk[2], msk[1], msk[0]));
    reqQ.push_back(req);
  endtask

  task automatic idle();
    @(negedge clk);
    checkOut();
    inValid = 1'b0;
    inTag = 3'd4;
    expQ.push_back('0);
    reqQ.push_back("R11");
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got run still active, expected completion");
    summary();
  end

  initial begin
    logic [63:0] r, r2, sg;
    int t, ex;
    repeat (3) @(negedge clk);
    // R12 reset state
    checks++;
    if ({outValid, outWrite, outData, flgInvalid, flgStackUnder, flgOverflow, flgUnderflow,
         flgPrecision, flgRoundUp} !== '0) begin
      fails++;
      $display("FAIL R12: got valid=%0b write=%0b data=%h, expected all zero", outValid, outWrite, outData);
    end
    rstN = 1'b1;
    idle();

    // R8 zero and infinity, R9 sign
    drive(0, 64'd0, 0, 1, 0, 4'hF, "R8");
    drive(1, 64'd0, 0, 1, 0, 4'hF, "R9");
    drive(0, 64'h8000_0000_0000_0000, 0, 2, 0, 4'h0, "R8");
    drive(1, 64'h8000_0000_0000_0000, 0, 2, 0, 4'h0, "R9");
    // R1 nearest: tie with even, tie with odd, above half, below half
    drive(0, 64'h8000_0000_0000_0400, 0, 0, 0, 4'hF, "R1");
    drive(0, 64'h8000_0000_0000_0C00, 0, 0, 0, 4'hF, "R1");
    drive(1, 64'h8000_0000_0000_0401, 3, 0, 0, 4'hF, "R1");
    drive(0, 64'hC000_0000_0000_03FF, -5, 0, 0, 4'hF, "R10");
    drive(0, 64'h8000_0000_0000_0800, 0, 0, 0, 4'hF, "R10");
    // R2 directed modes with each sign
    for (int m = 1; m < 4; m++) begin
      drive(0, 64'hA000_0000_0000_0001, 10, 0, m, 4'hF, "R2");
      drive(1, 64'hA000_0000_0000_0001, 10, 0, m, 4'hF, "R2");
    end
    idle();
    // R3 carry out
    drive(0, 64'hFFFF_FFFF_FFFF_FFFF, 5, 0, 0, 4'hF, "R3");
    drive(1, 64'hFFFF_FFFF_FFFF_F801, -1022, 0, 1, 4'hF, "R3");
    // R4 overflow through carry and directly, mask variants
    drive(0, 64'hFFFF_FFFF_FFFF_FFFF, 1023, 0, 0, 4'hF, "R4");
    drive(1, 64'hFFFF_FFFF_FFFF_FFFF, 1023, 0, 3, 4'hF, "R4");
    drive(1, 64'h8000_0000_0000_0000, 2000, 0, 0, 4'hF, "R4");
    drive(0, 64'h8000_0000_0000_0000, 1024, 0, 0, 4'hB, "R4");
    drive(0, 64'h8000_0000_0000_0000, 1024, 0, 0, 4'hE, "R4");
    // R5 subnormal path
    drive(0, 64'h8000_0000_0000_0000, -1023, 0, 0, 4'h0, "R5");
    drive(1, 64'hFFFF_FFFF_FFFF_FFFF, -1023, 0, 0, 4'hF, "R5");
    drive(0, 64'h8000_0000_0000_1234, -1030, 0, 0, 4'hF, "R5");
    drive(0, 64'h8000_0000_0000_1234, -1030, 0, 2, 4'hD, "R5");
    drive(0, 64'h8000_0000_0000_1234, -1030, 0, 2, 4'hE, "R5");
    drive(1, 64'hC000_0000_0000_0000, -1074, 0, 0, 4'hF, "R5");
    drive(1, 64'h8000_0000_0000_0001, -1100, 0, 1, 4'hF, "R5");
    drive(0, 64'h8000_0000_0000_0001, -30000, 0, 2, 4'hF, "R5");
    drive(0, 64'h8000_0000_0000_0001, -30000, 0, 0, 4'hF, "R5");
    // R6 NaN
    drive(0, 64'h8000_0000_0000_1000, 0, 3, 0, 4'hF, "R6");
    drive(1, 64'h8000_0000_0000_1000, 0, 3, 0, 4'h7, "R6");
    drive(1, 64'hC123_4567_89AB_C800, 0, 3, 0, 4'h0, "R6");
    // R7 empty
    drive(1, 64'h1234, 7, 4, 0, 4'hF, "R7");
    drive(0, 64'h1234, 7, 4, 0, 4'h7, "R7");
    drive(0, 64'h0, 0, 6, 0, 4'h8, "R7");
    idle();
    idle();

    // mixed stream
    for (int n = 0; n < 400; n++) begin
      r  = nextRand();
      r2 = nextRand();
      t  = (r[3:0] < 4'd10) ? 0 : int'(r[6:4]) % 5;
      case (r[9:8])
        2'd0: ex = int'(r[25:16]) - 512;
        2'd1: ex = -1023 - int'(r[23:16]);
        2'd2: ex = 1023 - int'(r[19:16]);
        default: ex = -1011 - int'(r[22:16]);
      endcase
      sg = r2;
      if (t == 0) sg[63] = 1'b1;
      if (t == 3) sg[63] = 1'b1;
      if (r[30]) sg[10:0] = {r[31], 10'd0};
      drive(r[12], sg, ex, t, int'(r[49:48]), r[43:40] | r[47:44], (t == 0) ? "R2" : "R9");
      if (r[55:52] == 4'd0) idle();
    end
    idle();
    idle();
    summary();
  end

endmodule